// File: doc/BRIEF.md
# Per-Channel Alarm Interrupt Register Bank

This block gathers line alarms for a six-channel line interface and turns them into a host interrupt. Each channel watches six alarm sources:

- a no-pulse monitor on the driver output;
- receive loss of signal;
- loss of lock;
- a jitter-FIFO near-limit comparison;
- a PRBS error indication;
- a PRBS error-counter saturation flag.

Any change of an alarm condition latches a status bit. The change can be into the alarm or back out of it. Status bits clear when the host reads them. A per-channel enable register chooses which latched bits may drive the single interrupt line.

The host reaches the registers over a plain byte-wide bus with separate read and write strobes. Read data is registered and appears in the cycle after the read strobe. Single-bit alarm inputs and the driver pulse indication pass through a two-flop synchronizer before they are used. The jitter-FIFO fill level and the attenuator enable are taken to be in the block's clock domain. The no-pulse monitor counts clock cycles in which the synchronized pulse indication is low.

Top module: `alarm_irq_bank`

## Requirements
- R1: Channel n (0..5) has its enable register at byte address 0x01 + 0x10·n and its status register at 0x02 + 0x10·n. A read of any other address returns 0x00. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled, and it holds until the next read.
- R2: Both registers use the same layout. Bit 0 is the driver no-pulse alarm, bit 1 is loss of receive signal, bit 2 is loss of lock, bit 3 is FIFO near-limit, bit 4 is PRBS error and bit 5 is PRBS count saturation. Bits 7:6 always read 0, and writes to them have no effect.
- R3: After reset, every enable and status register reads 0x00 and `irq` is low.
- R4: A status bit sets when its condition goes from clear to asserted, and again when it goes from asserted to clear. For synchronized inputs, the bit is visible at the third rising edge after the input changes.
- R5: A status read returns the value held before the read, and it clears the register to 0x00.
- R6: If a source changes in the same cycle as a clearing read of its status register, that bit is still set after the read.
- R7: The no-pulse condition asserts after exactly 128 consecutive synchronized cycles with `drv_pulse` low. It clears as soon as a pulse is seen, and this exit also sets bit 0.
- R8: With the jitter attenuator enabled, the near-limit condition holds when the fill level is 2 or less, or 30 or more, for a FIFO depth of 32. Levels 3 to 29 are normal.
- R9: While `ja_enable` for a channel is low, its near-limit condition is forced clear, so fill changes set no status bit. In that state, its bit 3 never raises `irq`, even if the bit is enabled.
- R10: The PRBS error input and the PRBS saturation input each set their own status bit (bit 4 and bit 5) on every change of level.
- R11: A write to an enable register stores bits 5:0, and a later read returns them.
- R12: `irq` is high exactly when some channel has a status bit set together with its enable bit, after the rule in R9 is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a status read clears that status register) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high interrupt |
| drv_pulse | input | 6 | Per-channel indication that a pulse was seen on the driver output |
| rx_los | input | 6 | Per-channel receive loss of signal |
| lock_loss | input | 6 | Per-channel loss of lock |
| ja_enable | input | 6 | Per-channel jitter attenuator enabled |
| fifo_fill | input | 36 | Per-channel jitter FIFO fill level, 6 bits per channel, channel 0 in the low bits |
| prbs_err | input | 6 | Per-channel PRBS error indication |
| prbs_sat | input | 6 | Per-channel PRBS error counter saturated |

## Verification
The hardest case to reach from the ports is a source change that lands in the same clock edge as a clearing read of the same register. The bench reaches it by counting the synchronizer stages: it flips a receive loss input and then issues the status read two falling edges later. At that point the edge detector is reporting the change, and the clear arrives on the same edge. The no-pulse monitor is checked on both sides of its 128-cycle threshold by stopping the pulses and reading the register before and after the limit.

// File: rtl/alarm_irq_pkg.sv
// Shared constants for the alarm interrupt bank: source bit positions
// within the enable and status registers, and register offsets.
package alarm_irq_pkg;
    localparam int N_SRC    = 6;
    localparam int BIT_DRV  = 0;
    localparam int BIT_LOS  = 1;
    localparam int BIT_LOL  = 2;
    localparam int BIT_FIFO = 3;
    localparam int BIT_PERR = 4;
    localparam int BIT_PSAT = 5;
    localparam int OFS_ENABLE = 1;
    localparam int OFS_STATUS = 2;
    localparam int CH_STRIDE  = 16;
endpackage

// File: rtl/alarm_sync.sv
// Two-flop synchronizer for a vector of independent single-bit levels.
// Assumes each bit is a slow level; no bus coherency is implied.
module alarm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages toward the block clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/nopulse_mon.sv
// Driver output no-pulse monitor: asserts idle after LIMIT consecutive
// cycles without a pulse, and clears on the first pulse. Assumes the
// pulse input is already synchronized.
module nopulse_mon #(
    parameter int LIMIT = 128,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic idle
);
    logic [CNT_W-1:0] cnt;

    // Count pulse-free cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (pulse)                cnt <= '0;
        else if (cnt != CNT_W'(LIMIT)) cnt <= cnt + 1'b1;
    end

    assign idle = (cnt == CNT_W'(LIMIT));

    // R7: a pulse always removes the idle condition on the next cycle
    a_r7_pulse_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !idle);
    // R7: idle can only appear after a pulse-free cycle
    a_r7_idle_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(!pulse));
endmodule

// File: rtl/alarm_channel.sv
// One channel of the alarm bank: synchronizes the alarm inputs, forms
// the six alarm conditions, detects every change, and holds the enable
// and clear-on-read status registers. Assumes fifo_fill and ja_en are
// already in the clk domain.
module alarm_channel
    import alarm_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NEAR  = 2,
    parameter int LIMIT = 128,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_pulse,
    input  logic              rx_los,
    input  logic              lock_loss,
    input  logic              ja_en,
    input  logic [FILL_W-1:0] fill,
    input  logic              prbs_err,
    input  logic              prbs_sat,
    input  logic              wr_en,
    input  logic              rd_clr,
    input  logic [N_SRC-1:0]  wdata,
    output logic [N_SRC-1:0]  en_q,
    output logic [N_SRC-1:0]  stat_q,
    output logic              irq
);
    logic [4:0]       raw, syn;
    logic             idle, near_lim;
    logic [N_SRC-1:0] cond, cond_q, evt, irq_mask;

    assign raw = {prbs_sat, prbs_err, lock_loss, rx_los, drv_pulse};

    alarm_sync #(.W(5)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    nopulse_mon #(.LIMIT(LIMIT)) u_nopulse (
        .clk(clk), .rst_n(rst_n), .pulse(syn[0]), .idle(idle)
    );

    // Near-limit comparison, forced clear while the attenuator is off.
    always_comb begin
        near_lim = ja_en && ((fill <= FILL_W'(NEAR)) ||
                             (fill >= FILL_W'(DEPTH - NEAR)));
    end

    // Assemble the conditions in register bit order.
    always_comb begin
        cond           = '0;
        cond[BIT_DRV]  = idle;
        cond[BIT_LOS]  = syn[1];
        cond[BIT_LOL]  = syn[2];
        cond[BIT_FIFO] = near_lim;
        cond[BIT_PERR] = syn[3];
        cond[BIT_PSAT] = syn[4];
    end

    // Previous condition, for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond;
    end

    assign evt = cond ^ cond_q;

    // Status: a clearing read drops old bits, and new events always win.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (rd_clr ? '0 : stat_q) | evt;
    end

    // Enable register write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata;
    end

    // The near-limit bit may not interrupt while the attenuator is off.
    always_comb begin
        irq_mask           = '1;
        irq_mask[BIT_FIFO] = ja_en;
    end

    assign irq = |(stat_q & en_q & irq_mask);

    // R4: every detected change is latched on the next edge
    a_r4_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
    // R5 / R6: after a clearing read only the coincident events remain
    a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (stat_q == $past(evt)));
    // R11: an enable write is stored as written
    a_r11_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wdata)));
    // R9: no near-limit condition while the attenuator is off
    a_r9_fifo_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        !ja_en |-> !near_lim);
    // R5: without an event or a read, the status holds
    a_r5_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !(|evt)) |=> $stable(stat_q));
endmodule

// File: rtl/alarm_irq_bank.sv
// Top of the six-channel alarm interrupt bank. Decodes the byte-wide
// host bus into per-channel enable and status registers, registers the
// read data, and ORs the channel interrupts. Assumes single-cycle
// strobes and that bus_wr and bus_rd are not used together on one address.
module alarm_irq_bank
    import alarm_irq_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DEPTH  = 32,
    parameter int NEAR   = 2,
    parameter int LIMIT  = 128,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    output logic                     irq,
    input  logic [NUM_CH-1:0]        drv_pulse,
    input  logic [NUM_CH-1:0]        rx_los,
    input  logic [NUM_CH-1:0]        lock_loss,
    input  logic [NUM_CH-1:0]        ja_enable,
    input  logic [NUM_CH*FILL_W-1:0] fifo_fill,
    input  logic [NUM_CH-1:0]        prbs_err,
    input  logic [NUM_CH-1:0]        prbs_sat
);
    logic [N_SRC-1:0]  en_q   [NUM_CH];
    logic [N_SRC-1:0]  stat_q [NUM_CH];
    logic [NUM_CH-1:0] sel_en, sel_st, ch_irq;
    logic [7:0]        rd_mux;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Address match for this channel's two registers.
        assign sel_en[c] = (bus_addr == 8'(c * CH_STRIDE + OFS_ENABLE));
        assign sel_st[c] = (bus_addr == 8'(c * CH_STRIDE + OFS_STATUS));

        alarm_channel #(.DEPTH(DEPTH), .NEAR(NEAR), .LIMIT(LIMIT)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .drv_pulse (drv_pulse[c]),
            .rx_los    (rx_los[c]),
            .lock_loss (lock_loss[c]),
            .ja_en     (ja_enable[c]),
            .fill      (fifo_fill[c*FILL_W +: FILL_W]),
            .prbs_err  (prbs_err[c]),
            .prbs_sat  (prbs_sat[c]),
            .wr_en     (bus_wr && sel_en[c]),
            .rd_clr    (bus_rd && sel_st[c]),
            .wdata     (bus_wdata[N_SRC-1:0]),
            .en_q      (en_q[c]),
            .stat_q    (stat_q[c]),
            .irq       (ch_irq[c])
        );
    end

    // Read multiplexer; unmapped addresses and reserved bits return zero.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_en[c]) rd_mux = {2'b00, en_q[c]};
            if (sel_st[c]) rd_mux = {2'b00, stat_q[c]};
        end
    end

    // Registered read data, held until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = |ch_irq;

    // R2: reserved bits never read back as one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:6] == 2'b00);
    // R1: read data only changes after a read strobe
    a_r1_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R12: no interrupt without some channel reporting one
    a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ch_irq != '0));
endmodule

// File: tb/alarm_irq_bank_tb.sv
module alarm_irq_bank_tb;
    localparam int NCH = 6;
    localparam int FW  = 6;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [7:0]      bus_addr = 0, bus_wdata = 0;
    logic            bus_wr = 0, bus_rd = 0;
    logic [7:0]      bus_rdata;
    logic            irq;
    logic [NCH-1:0]  drv_pulse = '1, rx_los = '0, lock_loss = '0;
    logic [NCH-1:0]  ja_enable = '1, prbs_err = '0, prbs_sat = '0;
    logic [NCH*FW-1:0] fifo_fill = {NCH{6'd16}};

    int checks = 0, failures = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    alarm_irq_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .drv_pulse(drv_pulse), .rx_los(rx_los),
        .lock_loss(lock_loss), .ja_enable(ja_enable), .fifo_fill(fifo_fill),
        .prbs_err(prbs_err), .prbs_sat(prbs_sat)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic settle(); repeat (6) @(negedge clk); endtask

    function automatic logic [7:0] en_a(int c); return 8'(c * 16 + 1); endfunction
    function automatic logic [7:0] st_a(int c); return 8'(c * 16 + 2); endfunction

    task automatic clear_all();
        for (int c = 0; c < NCH; c++) rd(st_a(c), rv);
    endtask

    task automatic t_reset();
        for (int c = 0; c < NCH; c++) begin
            rd(en_a(c), rv); check("R3 enable reset", rv, 8'h00);
            rd(st_a(c), rv); check("R3 status reset", rv, 8'h00);
        end
        check("R3 irq reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_map();
        for (int c = 0; c < NCH; c++) wr(en_a(c), 8'(8'hC0 | (c + 8'h11)));
        for (int c = 0; c < NCH; c++) begin
            rd(en_a(c), rv);
            check("R11 R2 enable readback", rv, 8'((c + 8'h11) & 8'h3F));
        end
        wr(8'h03, 8'hFF);
        rd(8'h03, rv); check("R1 unmapped addr", rv, 8'h00);
        rd(8'h61, rv); check("R1 addr past last channel", rv, 8'h00);
        rd(8'h00, rv); check("R1 addr 0", rv, 8'h00);
        for (int c = 0; c < NCH; c++) wr(en_a(c), 8'h00);
    endtask

    task automatic t_edges();
        clear_all();
        @(negedge clk); rx_los[1] = 1;
        settle(); rd(st_a(1), rv); check("R4 loss entry", rv, 8'h02);
        rd(st_a(1), rv); check("R5 cleared after read", rv, 8'h00);
        @(negedge clk); rx_los[1] = 0; lock_loss[1] = 1;
        settle(); rd(st_a(1), rv); check("R4 exit and lock", rv, 8'h06);
        rd(st_a(0), rv); check("R4 other channel untouched", rv, 8'h00);
        @(negedge clk); lock_loss[1] = 0;
        settle(); clear_all();
    endtask

    task automatic t_collision();
        @(negedge clk); rx_los[4] = 1;
        settle();
        rx_los[4] = 0;                       // driven at a falling edge
        @(negedge clk); @(negedge clk);
        bus_addr = st_a(4); bus_rd = 1;      // clear coincides with event
        @(negedge clk); bus_rd = 0;
        check("R5 read returns old value", bus_rdata, 8'h02);
        rd(st_a(4), rv); check("R6 coincident event kept", rv, 8'h02);
        rd(st_a(4), rv); check("R6 then cleared", rv, 8'h00);
    endtask

    task automatic t_nopulse();
        clear_all();
        @(negedge clk); drv_pulse[2] = 0;
        repeat (120) @(negedge clk);
        rd(st_a(2), rv); check("R7 below 128 cycles", rv, 8'h00);
        repeat (20) @(negedge clk);
        rd(st_a(2), rv); check("R7 idle alarm entry", rv, 8'h01);
        @(negedge clk); drv_pulse[2] = 1;
        settle(); rd(st_a(2), rv); check("R7 idle alarm exit", rv, 8'h01);
    endtask

    task automatic t_fifo();
        clear_all();
        fifo_fill[2*FW +: FW] = 6'd3;
        settle(); rd(st_a(2), rv); check("R8 level 3 normal", rv, 8'h00);
        fifo_fill[2*FW +: FW] = 6'd2;
        settle(); rd(st_a(2), rv); check("R8 level 2 near empty", rv, 8'h08);
        fifo_fill[2*FW +: FW] = 6'd29;
        settle(); rd(st_a(2), rv); check("R8 leave to 29", rv, 8'h08);
        fifo_fill[2*FW +: FW] = 6'd30;
        settle(); rd(st_a(2), rv); check("R8 level 30 near full", rv, 8'h08);
        fifo_fill[2*FW +: FW] = 6'd16;
        settle(); clear_all();
        ja_enable[2] = 0;
        wr(en_a(2), 8'h08);
        fifo_fill[2*FW +: FW] = 6'd0;
        settle();
        check("R9 no irq when attenuator off", {7'b0, irq}, 8'h00);
        rd(st_a(2), rv); check("R9 no status when attenuator off", rv, 8'h00);
        fifo_fill[2*FW +: FW] = 6'd16;
        settle(); ja_enable[2] = 1;
        settle(); wr(en_a(2), 8'h00); clear_all();
    endtask

    task automatic t_prbs();
        clear_all();
        @(negedge clk); prbs_err[5] = 1; prbs_sat[5] = 1;
        settle(); rd(st_a(5), rv); check("R10 prbs bits set", rv, 8'h30);
        @(negedge clk); prbs_err[5] = 0;
        settle(); rd(st_a(5), rv); check("R10 prbs error release", rv, 8'h10);
        @(negedge clk); prbs_sat[5] = 0;
        settle(); clear_all();
    endtask

    task automatic t_irq();
        clear_all();
        wr(en_a(3), 8'h02);
        @(negedge clk); lock_loss[3] = 1;
        settle(); check("R12 disabled bit no irq", {7'b0, irq}, 8'h00);
        @(negedge clk); rx_los[3] = 1;
        settle(); check("R12 enabled bit raises irq", {7'b0, irq}, 8'h01);
        rd(st_a(3), rv); check("R12 status content", rv, 8'h06);
        check("R12 irq drops after clear", {7'b0, irq}, 8'h00);
        wr(en_a(3), 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_map();
        t_edges();
        t_collision();
        t_nopulse();
        t_fifo();
        t_prbs();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule